// File: doc/BRIEF.md
# Service Request Mailbox

This block is a memory-mapped mailbox. A host uses it to hand work to a system controller and to collect the result. The host reaches it over a simple 32-bit register bus. Through that bus it sees a control register, a status register, an interrupt-clear register and a word-addressed mailbox RAM.

The host first stores command words in the RAM. It then writes a request to the control register. The 16-bit command field of that request carries a 7-bit opcode in its low bits and a byte offset into the RAM above them. The block raises busy and starts a stub service engine. The engine fetches the first command word at that offset and waits a programmable number of cycles. It then stores the bitwise inverse of the word in the following RAM word and posts a 16-bit status code. If the request asked for notification, an interrupt is raised once busy has dropped. The host clears the interrupt by writing zero to the clear register. A running service can be cut short with an abort request.

Read data appears on the bus one cycle after the read strobe. The RAM window has two properties the host depends on. Any word reads back exactly what was last written to it, so the host can merge partial trailing bytes with a read-modify-write. Accesses beyond the configured depth are harmless.

Top module: `svc_mailbox`

## Requirements
- R1: After reset, busy and the interrupt output are 0, and the control, status and interrupt-clear registers all read 0.
- R2: Registers sit at byte address 0x050 (control), 0x054 (status) and 0x058 (interrupt clear). RAM word i sits at 0x800 + 4*i. Read data is valid in the cycle after the read strobe. A RAM word returns the value last written to it.
- R3: A RAM access whose word index (address bits 10:2, with address bit 11 set) is DEPTH or more reads as zero, and its write is ignored.
- R4: A control write with bit 0 (request) set while idle starts a service. The control register then reads busy in bit 1, the command field in bits 31:16, notify in bit 3, and 0 in bit 0. In the command field, bits 6:0 are the opcode and bits 15:7 are the byte offset.
- R5: A request written while busy is ignored. The command field keeps its value, and the running service completes exactly as it would have otherwise.
- R6: For an opcode below 0x40, the engine reads RAM word (byte offset / 4). It writes the bitwise inverse of that word to the next word and posts status 0.
- R7: For an opcode of 0x40 or above, the posted status is 0x0001 and the response word is left unchanged.
- R8: With notify (control bit 3) set, the interrupt rises exactly LATENCY+4 clock edges after the edge that accepts the request. At that point status bit 1 reads 0 and status bits 31:16 hold the posted code.
- R9: A request without notify completes without raising the interrupt.
- R10: The interrupt rises only while busy is 0. Writing 0 to the interrupt-clear register clears it. Writing a nonzero value leaves it set. The interrupt-clear register reads the interrupt in bit 0.
- R11: A control write with bit 2 (abort) set while busy ends the service. The posted status is 0xFFFF and no response word is written. Abort while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with DEPTH=64 and LATENCY=9. With that depth, the upper part of the 0x800 window (0x900 to 0xFFC) lies beyond the RAM, so the out-of-range read and write behaviour can be tested at the ports. The short latency keeps each random service quick and leaves room for an abort in the middle of the wait. It also lets the exact interrupt timing be compared with a count derived from LATENCY. Random opcodes cover both the success and the failure codes, and the offsets stay inside the smaller RAM.

// File: rtl/svc_mbox_pkg.sv
package svc_mbox_pkg;
  localparam logic [11:0] CTRL_ADDR  = 12'h050;
  localparam logic [11:0] STAT_ADDR  = 12'h054;
  localparam logic [11:0] ICLR_ADDR  = 12'h058;
  localparam logic [15:0] ABORT_CODE = 16'hFFFF;
  localparam logic [15:0] FAIL_CODE  = 16'h0001;
  localparam logic [6:0]  FAIL_OP_MIN = 7'h40;
  localparam int          XW = 10;

  typedef enum logic [2:0] {
    ENG_IDLE, ENG_RD, ENG_CAP, ENG_WAIT, ENG_WR
  } eng_state_e;
endpackage

// File: rtl/svc_mbox_ram.sv
module svc_mbox_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [31:0]   a_wdata,
  output logic [31:0]   a_q,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [31:0]   b_wdata,
  output logic [31:0]   b_q
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_q <= mem[a_addr];
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/svc_mbox_engine.sv
module svc_mbox_engine
  import svc_mbox_pkg::*;
#(
  parameter int LATENCY = 16,
  parameter int IDX_W   = 8,
  parameter int CNT_W   = $clog2(LATENCY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [6:0]       opcode_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             abort_i,
  output logic [IDX_W-1:0] idx_o,
  input  logic [31:0]      rd_data_i,
  output logic             wr_en_o,
  output logic [31:0]      wr_data_o,
  output logic             active_o,
  output logic             done_o,
  output logic [15:0]      status_o
);
  eng_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [6:0]       op_q;
  logic [31:0]      word_q;
  logic [CNT_W-1:0] cnt_q;
  logic             op_ok;
  logic             kill;

  assign op_ok    = op_q < FAIL_OP_MIN;
  assign active_o = state_q != ENG_IDLE;
  assign kill     = active_o && abort_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
      idx_q   <= '0;
      op_q    <= '0;
      word_q  <= '0;
      cnt_q   <= '0;
    end else if (kill) begin
      state_q <= ENG_IDLE;
    end else begin
      case (state_q)
        ENG_IDLE: if (start_i) begin
          idx_q   <= idx_i;
          op_q    <= opcode_i;
          state_q <= ENG_RD;
        end
        ENG_RD:  state_q <= ENG_CAP;
        ENG_CAP: begin
          word_q  <= rd_data_i;
          cnt_q   <= CNT_W'(LATENCY - 1);
          state_q <= ENG_WAIT;
        end
        ENG_WAIT: begin
          if (cnt_q == '0) state_q <= ENG_WR;
          else             cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign idx_o     = (state_q == ENG_WR) ? idx_q + IDX_W'(1) : idx_q;
  assign wr_en_o   = (state_q == ENG_WR) && !abort_i && op_ok;
  assign wr_data_o = ~word_q;
  assign done_o    = (state_q == ENG_WR) || kill;
  assign status_o  = kill ? ABORT_CODE : (op_ok ? 16'h0000 : FAIL_CODE);

  // R11
  abort_stop_chk: assert property (@(posedge clk) disable iff (rst)
    kill |=> state_q == ENG_IDLE);
  // R8
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
    state_q == ENG_WAIT |-> cnt_q < CNT_W'(LATENCY));
endmodule

// File: rtl/svc_mailbox.sv
module svc_mailbox
  import svc_mbox_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int LATENCY = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int IDX_W = 8;
  localparam logic [XW-1:0] DEPTH_X = XW'(DEPTH);

  logic        busy_q, notify_q, pend_q, irq_q;
  logic [15:0] cmd_q, status_q;
  logic        ctrl_wr, accept, abort_req, iclr_wr;
  logic [XW-1:0] host_idx, eng_idx_x;
  logic        host_in, eng_in, eng_rd_ok_q, rd_ram_q;
  logic [31:0] ram_a_q, ram_b_q, reg_rd, reg_q, eng_rd_data;
  logic [IDX_W-1:0] eng_idx;
  logic        eng_we, eng_active, eng_done;
  logic [31:0] eng_wdata;
  logic [15:0] eng_status;

  assign ctrl_wr   = bus_wr && bus_addr == CTRL_ADDR;
  assign iclr_wr   = bus_wr && bus_addr == ICLR_ADDR;
  assign accept    = ctrl_wr && bus_wdata[0] && !busy_q;
  assign abort_req = ctrl_wr && bus_wdata[2] && busy_q;

  assign host_idx  = {1'b0, bus_addr[10:2]};
  assign host_in   = bus_addr[11] && host_idx < DEPTH_X;
  assign eng_idx_x = {{(XW-IDX_W){1'b0}}, eng_idx};
  assign eng_in    = eng_idx_x < DEPTH_X;

  svc_mbox_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk     (clk),
    .a_we    (bus_wr && host_in),
    .a_addr  (host_idx[AW-1:0]),
    .a_wdata (bus_wdata),
    .a_q     (ram_a_q),
    .b_we    (eng_we && eng_in),
    .b_addr  (eng_idx_x[AW-1:0]),
    .b_wdata (eng_wdata),
    .b_q     (ram_b_q)
  );

  assign eng_rd_data = eng_rd_ok_q ? ram_b_q : 32'h0;

  svc_mbox_engine #(.LATENCY(LATENCY), .IDX_W(IDX_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .start_i   (accept),
    .opcode_i  (bus_wdata[22:16]),
    .idx_i     ({1'b0, bus_wdata[31:25]}),
    .abort_i   (abort_req),
    .idx_o     (eng_idx),
    .rd_data_i (eng_rd_data),
    .wr_en_o   (eng_we),
    .wr_data_o (eng_wdata),
    .active_o  (eng_active),
    .done_o    (eng_done),
    .status_o  (eng_status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      notify_q <= 1'b0;
      cmd_q    <= '0;
      status_q <= '0;
      pend_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (accept) begin
        busy_q   <= 1'b1;
        cmd_q    <= bus_wdata[31:16];
        notify_q <= bus_wdata[3];
      end
      if (eng_done) begin
        busy_q   <= 1'b0;
        status_q <= eng_status;
      end
      pend_q <= eng_done && notify_q;
      if (pend_q)                          irq_q <= 1'b1;
      else if (iclr_wr && bus_wdata == '0) irq_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      CTRL_ADDR: reg_rd = {cmd_q, 12'h0, notify_q, 1'b0, busy_q, 1'b0};
      STAT_ADDR: reg_rd = {status_q, 14'h0, busy_q, 1'b0};
      ICLR_ADDR: reg_rd = {31'h0, irq_q};
      default:   reg_rd = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q       <= '0;
      rd_ram_q    <= 1'b0;
      eng_rd_ok_q <= 1'b0;
    end else begin
      reg_q       <= bus_rd ? reg_rd : 32'h0;
      rd_ram_q    <= bus_rd && host_in;
      eng_rd_ok_q <= eng_in;
    end
  end

  assign bus_rdata = rd_ram_q ? ram_a_q : reg_q;
  assign irq       = irq_q;

  // R10
  irq_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> !busy_q);
  // R9
  irq_needs_notify_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> notify_q);
  // R5
  busy_req_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && bus_wdata[0] && busy_q) |=> $stable(cmd_q));
  // R4
  engine_under_busy_chk: assert property (@(posedge clk) disable iff (rst)
    eng_active |-> busy_q);
endmodule

// File: tb/tb_svc_mailbox.sv
module tb_svc_mailbox;
  localparam int DEPTH = 64;
  localparam int LAT   = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  svc_mailbox #(.DEPTH(DEPTH), .LATENCY(LAT)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [15:0] exp_status(input logic [6:0] op);
    return (op < 7'h40) ? 16'h0000 : 16'h0001;
  endfunction

  function automatic logic [31:0] req_word(input logic [6:0] op, input int widx,
                                           input bit notify);
    logic [8:0] ofs = 9'(widx * 4);
    return {ofs, op, 12'h0, notify, 3'b001};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < LAT + 60) begin @(posedge clk); #1; n++; end
    check(req, {31'h0, irq}, 32'h1);
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    int n = 0;
    rd(12'h054, s);
    while (s[1] && n < LAT + 60) begin rd(12'h054, s); n++; end
    check(req, {31'h0, s[1]}, 32'h0);
  endtask

  task automatic clear_irq();
    wr(12'h058, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, d, pf;
    int seed;
    seed = $urandom(20240);
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    rd(12'h050, v); check("R1 ctrl", v, 32'h0);
    rd(12'h054, v); check("R1 stat", v, 32'h0);
    rd(12'h058, v); check("R1 iclr", v, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R2 RAM read-back
    for (int i = 0; i < DEPTH; i += 7) begin
      d = $urandom;
      wr(12'(12'h800 + i * 4), d);
      rd(12'(12'h800 + i * 4), v);
      check("R2 ram readback", v, d);
    end
    wr(12'h8FC, 32'h1234_5678);
    rd(12'h8FC, v); check("R2 last word", v, 32'h1234_5678);

    // R3 out of range
    wr(12'h900, 32'hDEAD_BEEF);
    rd(12'h900, v); check("R3 oor 0x900", v, 32'h0);
    wr(12'hFFC, 32'hCAFE_F00D);
    rd(12'hFFC, v); check("R3 oor 0xFFC", v, 32'h0);
    rd(12'h800, v); check("R3 no alias", v === 32'hDEAD_BEEF ? 32'h1 : 32'h0, 32'h0);

    // R6 R8 R4 directed success with timing
    wr(12'h810, 32'h0F0F_1234);
    wr(12'h814, 32'h0);
    begin
      int n = 0;
      @(negedge clk); bus_wr = 1'b1; bus_addr = 12'h050; bus_wdata = req_word(7'h12, 4, 1'b1);
      @(posedge clk); #1 bus_wr = 1'b0;
      while (!irq && n < LAT + 60) begin @(posedge clk); #1; n++; end
      check("R8 irq latency", 32'(n), 32'(LAT + 4));
    end
    rd(12'h054, v);
    check("R8 busy clear", {31'h0, v[1]}, 32'h0);
    check("R6 status ok", {16'h0, v[31:16]}, 32'h0);
    rd(12'h814, v); check("R6 response", v, ~32'h0F0F_1234);
    rd(12'h050, v);
    check("R4 cmd field", {16'h0, v[31:16]}, {16'h0, 9'd16, 7'h12});
    check("R4 req self-clear", {31'h0, v[0]}, 32'h0);
    rd(12'h058, v); check("R10 iclr reads irq", v, 32'h1);
    wr(12'h058, 32'h1);
    check("R10 nonzero clear ignored", {31'h0, irq}, 32'h1);
    clear_irq();
    check("R10 zero clears", {31'h0, irq}, 32'h0);

    // R4 busy visible while running
    wr(12'h820, 32'h5);
    wr(12'h050, req_word(7'h01, 8, 1'b0));
    rd(12'h050, v); check("R4 busy bit", {31'h0, v[1]}, 32'h1);
    wait_idle("R4 idle");
    rd(12'h824, v); check("R9 response no notify", v, ~32'h5);
    check("R9 no irq", {31'h0, irq}, 32'h0);

    // R7 failing opcode
    wr(12'h830, 32'h1111_2222);
    wr(12'h834, 32'hA5A5_A5A5);
    wr(12'h050, req_word(7'h45, 12, 1'b1));
    wait_irq("R7 irq");
    rd(12'h054, v); check("R7 status", {16'h0, v[31:16]}, 32'h1);
    rd(12'h834, v); check("R7 untouched", v, 32'hA5A5_A5A5);
    clear_irq();

    // R5 request while busy
    wr(12'h840, 32'h7777_0000);
    wr(12'h844, 32'h0);
    wr(12'h864, 32'h3C3C_3C3C);
    wr(12'h050, req_word(7'h05, 16, 1'b1));
    wr(12'h050, req_word(7'h50, 24, 1'b1));
    rd(12'h050, v); check("R5 cmd kept", {16'h0, v[31:16]}, {16'h0, 9'd64, 7'h05});
    wait_irq("R5 irq");
    rd(12'h054, v); check("R5 status", {16'h0, v[31:16]}, 32'h0);
    rd(12'h844, v); check("R5 first response", v, ~32'h7777_0000);
    rd(12'h864, v); check("R5 second not run", v, 32'h3C3C_3C3C);
    clear_irq();

    // R11 abort
    wr(12'h850, 32'h9);
    wr(12'h854, 32'h6666_6666);
    wr(12'h050, req_word(7'h02, 20, 1'b1));
    wr(12'h050, 32'h4);
    wait_irq("R11 irq");
    rd(12'h054, v); check("R11 status", {16'h0, v[31:16]}, 32'hFFFF);
    rd(12'h854, v); check("R11 no write", v, 32'h6666_6666);
    clear_irq();
    wr(12'h050, 32'h4);
    rd(12'h054, v); check("R11 idle abort", v, 32'hFFFF_0000);

    // R6 R7 random services
    for (int k = 0; k < 24; k++) begin
      int widx = $urandom % 30;
      logic [6:0] op = 7'($urandom);
      d  = $urandom;
      pf = $urandom;
      wr(12'(12'h800 + widx * 4), d);
      wr(12'(12'h800 + widx * 4 + 4), pf);
      wr(12'h050, req_word(op, widx, 1'b1));
      wait_irq("R8 rand irq");
      rd(12'h054, v);
      check("R6 R7 rand status", {16'h0, v[31:16]}, {16'h0, exp_status(op)});
      rd(12'(12'h800 + widx * 4 + 4), v);
      check("R6 R7 rand response", v, (op < 7'h40) ? ~d : pf);
      rd(12'(12'h800 + widx * 4), v);
      check("R2 rand cmd word", v, d);
      clear_irq();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule